// File: doc/BRIEF.md
# Legacy VGA I/O Register Decoder

This block answers byte-wide I/O cycles in the legacy display port window 3B0h–3DFh. Most of the display state is reached through index/data port pairs. Writing the index port selects a location, and the data port then reads or writes the small register array behind that index. Five such groups exist: sequencer, graphics controller, CRT controller, attribute controller and an extension group. The CRT controller answers at both its monochrome and its colour port pair, and both pairs reach the same storage. The attribute controller has a single write port. Writes to it alternate between index and data under an internal toggle, and a read of the input status port returns that toggle to the index state.

The block also holds the palette port set: a pixel mask, separate read and write palette indices, a DAC state byte, and a small palette store whose data port steps through three colour components per entry. Three direct ports complete the map: input status, feature control and misc output. At some of these addresses a read returns a different register from the one a write updates.

A host drives one strobe per cycle. Read data is registered and appears one cycle after the read strobe, qualified by a valid pulse.

Top module: `vga_io_decoder`

## Requirements
- R1: Each indexed group has an index port and a data port, with the data port at index port + 1: sequencer 3C4h, graphics 3CEh, extension 3D6h, and CRT controller at both 3B4h and 3D4h. The CRT controller's two port pairs share one index and one array. An index read returns all 8 bits written. The data port reads and writes the array entry selected by the low log2(depth) index bits; CRT depth is 32.
- R2: Writes to 3C0h alternate. After reset, or after the toggle has been cleared, the first write sets the attribute index and the next write stores data at that index.
- R3: A read of 3C0h returns the attribute index. A read of 3C1h returns the attribute data at that index. Writes to 3C1h change nothing.
- R4: A read of 3BAh or 3DAh returns status with bit 3 = vretrace_i, bit 0 = dispoff_i and all other bits 0. Such a read returns the 3C0h toggle to the index state.
- R5: A write to 3BAh or 3DAh sets feature control, which reads back at 3CAh. Writes to 3CAh change nothing.
- R6: A write to 3C2h sets misc output, which reads back at 3CCh. Writes to 3CCh change nothing, and a read of 3C2h returns 00h.
- R7: 3C6h is the pixel mask, readable and writable, and it resets to FFh.
- R8: A write to 3C8h sets the palette write index and restarts its component count, and a read of 3C8h returns the write index. A write to 3C7h sets the separate read index and restarts its component count. A read of 3C7h returns 03h if the last index write went to 3C7h, and 00h otherwise.
- R9: Accesses to 3C9h move through components 0, 1, 2 of the addressed entry, then advance that side's index by one. Writes use the write index, reads use the read index, and the two never disturb each other.
- R10: Every address with no function listed here, inside or outside 3B0h–3DFh (for example 3B0h, 3C3h, 3D8h, 3DFh, 3E0h), reads as 00h, and writes to it change no state.
- R11: Reset clears every index, the 3C0h toggle, feature control, misc output, both palette component counts and io_rdata, and sets io_rvalid to 0.
- R12: io_rvalid pulses in the cycle after each read strobe and only then. io_rdata holds the last read result until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | DATA_W | Write data |
| vretrace_i | input | 1 | Vertical retrace flag reported in status |
| dispoff_i | input | 1 | Display-inactive flag reported in status |
| io_rdata | output | DATA_W | Registered read data |
| io_rvalid | output | 1 | High in the cycle io_rdata carries a new result |

## Verification
The bench reads the attribute index, clears the toggle with a status read, then writes 3C0h again. A design that ignored the clear would store that write as data, and the index would read back wrong. Palette tests restart the write index in the middle of a triplet, and the read index in the middle of one. A component counter that did not reset would shift every later colour by one slot. The bench also writes and reads the same entries through both sides, which exposes any shared read/write index. CRT data written through the colour pair is read back through the monochrome pair, and an index above the array depth is used to check aliasing. A design that writes through a port that is read-only, or through a reserved port, would change a value that the bench reads back afterwards.

// File: rtl/vga_io_pkg.sv
package vga_io_pkg;

  typedef enum logic [4:0] {
    P_NONE, P_CRT_IDX, P_CRT_DAT, P_STAT, P_ATT_IW, P_ATT_RD, P_MISC_W,
    P_SEQ_IDX, P_SEQ_DAT, P_MASK, P_PAL_RIDX, P_PAL_WIDX, P_PAL_DAT,
    P_FEAT_RD, P_MISC_RD, P_GFX_IDX, P_GFX_DAT, P_EXT_IDX, P_EXT_DAT
  } port_e;

  localparam int G_SEQ = 0;
  localparam int G_GFX = 1;
  localparam int G_CRT = 2;
  localparam int G_ATT = 3;
  localparam int G_EXT = 4;
  localparam int NGRP  = 5;

  function automatic port_e port_of(input logic [15:0] a);
    case (a)
      16'h03B4, 16'h03D4: return P_CRT_IDX;
      16'h03B5, 16'h03D5: return P_CRT_DAT;
      16'h03BA, 16'h03DA: return P_STAT;
      16'h03C0:           return P_ATT_IW;
      16'h03C1:           return P_ATT_RD;
      16'h03C2:           return P_MISC_W;
      16'h03C4:           return P_SEQ_IDX;
      16'h03C5:           return P_SEQ_DAT;
      16'h03C6:           return P_MASK;
      16'h03C7:           return P_PAL_RIDX;
      16'h03C8:           return P_PAL_WIDX;
      16'h03C9:           return P_PAL_DAT;
      16'h03CA:           return P_FEAT_RD;
      16'h03CC:           return P_MISC_RD;
      16'h03CE:           return P_GFX_IDX;
      16'h03CF:           return P_GFX_DAT;
      16'h03D6:           return P_EXT_IDX;
      16'h03D7:           return P_EXT_DAT;
      default:            return P_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vga_index_group.sv
// Index register plus a small array addressed by the index's low bits.
module vga_index_group #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         idx_we,
  input  logic         dat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] idx_q,
  output logic [W-1:0] dat_q
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] sel;

  assign sel = idx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_we) idx_q <= wdata;
  end

  // array has no reset so it can map onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (dat_we) mem[sel] <= wdata;
  end

  assign dat_q = mem[sel];
endmodule

// File: rtl/vga_palette.sv
// Palette port set: mask, split read/write indices, three-component store.
module vga_palette #(
  parameter int ENTRIES = 16,
  parameter int W       = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic         ridx_we,
  input  logic         widx_we,
  input  logic         dat_we,
  input  logic         dat_re,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] widx_q,
  output logic         rd_mode,
  output logic [W-1:0] dat_q
);
  localparam int IW    = $clog2(ENTRIES);
  localparam int SLOTS = ENTRIES * 3;
  localparam int MW    = $clog2(SLOTS);

  logic [W-1:0]  mem [SLOTS];
  logic [W-1:0]  ridx_q;
  logic [1:0]    wcomp, rcomp;
  logic [MW-1:0] wa, ra;

  assign wa = MW'(widx_q[IW-1:0]) * MW'(3) + MW'(wcomp);
  assign ra = MW'(ridx_q[IW-1:0]) * MW'(3) + MW'(rcomp);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      widx_q  <= '0;
      ridx_q  <= '0;
      wcomp   <= '0;
      rcomp   <= '0;
      rd_mode <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      if (widx_we) begin
        widx_q  <= wdata;
        wcomp   <= '0;
        rd_mode <= 1'b0;
      end else if (dat_we) begin
        if (wcomp == 2'd2) begin
          wcomp  <= '0;
          widx_q <= widx_q + W'(1);
        end else begin
          wcomp <= wcomp + 2'd1;
        end
      end
      if (ridx_we) begin
        ridx_q  <= wdata;
        rcomp   <= '0;
        rd_mode <= 1'b1;
      end else if (dat_re) begin
        if (rcomp == 2'd2) begin
          rcomp  <= '0;
          ridx_q <= ridx_q + W'(1);
        end else begin
          rcomp <= rcomp + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dat_we) mem[wa] <= wdata;
  end

  assign dat_q = mem[ra];
endmodule

// File: rtl/vga_io_decoder.sv
module vga_io_decoder
  import vga_io_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SEQ_DEPTH   = 8,
  parameter int GFX_DEPTH   = 16,
  parameter int CRT_DEPTH   = 32,
  parameter int ATT_DEPTH   = 32,
  parameter int EXT_DEPTH   = 16,
  parameter int PAL_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              vretrace_i,
  input  logic              dispoff_i,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid
);
  port_e port;
  assign port = port_of(16'(io_addr));

  logic              att_ff;
  logic [DATA_W-1:0] feat_q, misc_q;
  logic [NGRP-1:0]   g_iwe, g_dwe;
  logic [DATA_W-1:0] g_idx [NGRP];
  logic [DATA_W-1:0] g_dat [NGRP];

  // write steering into the indexed groups
  always_comb begin
    g_iwe = '0;
    g_dwe = '0;
    if (io_wr) begin
      case (port)
        P_SEQ_IDX: g_iwe[G_SEQ] = 1'b1;
        P_SEQ_DAT: g_dwe[G_SEQ] = 1'b1;
        P_GFX_IDX: g_iwe[G_GFX] = 1'b1;
        P_GFX_DAT: g_dwe[G_GFX] = 1'b1;
        P_CRT_IDX: g_iwe[G_CRT] = 1'b1;
        P_CRT_DAT: g_dwe[G_CRT] = 1'b1;
        P_EXT_IDX: g_iwe[G_EXT] = 1'b1;
        P_EXT_DAT: g_dwe[G_EXT] = 1'b1;
        P_ATT_IW: begin
          if (att_ff) g_dwe[G_ATT] = 1'b1;
          else        g_iwe[G_ATT] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int D = (g == G_SEQ) ? SEQ_DEPTH :
                       (g == G_GFX) ? GFX_DEPTH :
                       (g == G_CRT) ? CRT_DEPTH :
                       (g == G_ATT) ? ATT_DEPTH : EXT_DEPTH;
    vga_index_group #(.DEPTH(D), .W(DATA_W)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .idx_we (g_iwe[g]),
      .dat_we (g_dwe[g]),
      .wdata  (io_wdata),
      .idx_q  (g_idx[g]),
      .dat_q  (g_dat[g])
    );
  end

  // attribute toggle: status read forces it back to the index state
  always_ff @(posedge clk) begin
    if (rst)                          att_ff <= 1'b0;
    else if (io_rd && port == P_STAT) att_ff <= 1'b0;
    else if (io_wr && port == P_ATT_IW) att_ff <= ~att_ff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q <= '0;
      misc_q <= '0;
    end else if (io_wr) begin
      if (port == P_STAT)   feat_q <= io_wdata;
      if (port == P_MISC_W) misc_q <= io_wdata;
    end
  end

  logic [DATA_W-1:0] pal_mask, pal_widx, pal_dat;
  logic              pal_rmode;

  vga_palette #(.ENTRIES(PAL_ENTRIES), .W(DATA_W)) u_pal (
    .clk     (clk),
    .rst     (rst),
    .mask_we (io_wr && port == P_MASK),
    .ridx_we (io_wr && port == P_PAL_RIDX),
    .widx_we (io_wr && port == P_PAL_WIDX),
    .dat_we  (io_wr && port == P_PAL_DAT),
    .dat_re  (io_rd && port == P_PAL_DAT),
    .wdata   (io_wdata),
    .mask_q  (pal_mask),
    .widx_q  (pal_widx),
    .rd_mode (pal_rmode),
    .dat_q   (pal_dat)
  );

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (port)
      P_SEQ_IDX:  rd_next = g_idx[G_SEQ];
      P_SEQ_DAT:  rd_next = g_dat[G_SEQ];
      P_GFX_IDX:  rd_next = g_idx[G_GFX];
      P_GFX_DAT:  rd_next = g_dat[G_GFX];
      P_CRT_IDX:  rd_next = g_idx[G_CRT];
      P_CRT_DAT:  rd_next = g_dat[G_CRT];
      P_EXT_IDX:  rd_next = g_idx[G_EXT];
      P_EXT_DAT:  rd_next = g_dat[G_EXT];
      P_ATT_IW:   rd_next = g_idx[G_ATT];
      P_ATT_RD:   rd_next = g_dat[G_ATT];
      P_STAT: begin
        rd_next[3] = vretrace_i;
        rd_next[0] = dispoff_i;
      end
      P_FEAT_RD:  rd_next = feat_q;
      P_MISC_RD:  rd_next = misc_q;
      P_MASK:     rd_next = pal_mask;
      P_PAL_RIDX: rd_next = pal_rmode ? DATA_W'(3) : '0;
      P_PAL_WIDX: rd_next = pal_widx;
      P_PAL_DAT:  rd_next = pal_dat;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) io_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/vga_io_decoder_chk.sv
module vga_io_decoder_chk
  import vga_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              vretrace_i,
  input logic              dispoff_i,
  input logic [DATA_W-1:0] io_rdata,
  input logic              io_rvalid,
  input logic              att_ff,
  input logic [DATA_W-1:0] feat_q,
  input logic [DATA_W-1:0] misc_q
);
  port_e cport;
  assign cport = port_of(16'(io_addr));

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> io_rvalid); // R12
  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> !io_rvalid); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata)); // R12
  AST_ATT_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (io_wr && cport == P_ATT_IW) |=> (att_ff != $past(att_ff))); // R2
  AST_STATUS_CLEARS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (io_rd && cport == P_STAT) |=> !att_ff); // R4
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (rst)
    (io_rd && cport == P_STAT) |=>
      (io_rdata[3] == $past(vretrace_i) && io_rdata[0] == $past(dispoff_i)
       && $countones(io_rdata) == $countones({$past(vretrace_i), $past(dispoff_i)}))); // R4
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (io_rd && cport == P_NONE) |=> (io_rdata == '0)); // R10
  AST_FEAT_ONLY_VIA_STATUS: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && cport == P_STAT) |=> $stable(feat_q)); // R5
  AST_MISC_ONLY_VIA_3C2: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && cport == P_MISC_W) |=> $stable(misc_q)); // R6
endmodule

bind vga_io_decoder vga_io_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/vga_io_decoder_test.sv
`timescale 1ns/1ps
module vga_io_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        vretrace_i = 1'b0;
  logic        dispoff_i = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  vga_io_decoder uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .vretrace_i(vretrace_i), .dispoff_i(dispoff_i),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // driver: queue the expected byte, then issue the read
  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  // monitor: registered result is stable at the falling edge after the read
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected valid actual %02h expected none", io_rdata);
      end else begin
        chk(io_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(io_rdata, 8'h00, "R11 rdata after reset");
    chk({7'b0, io_rvalid}, 8'h00, "R11 rvalid after reset");
    rd(16'h03C8, 8'h00, "R11 write index");
    rd(16'h03C7, 8'h00, "R11 dac state");
    rd(16'h03C6, 8'hFF, "R7 mask reset");
    rd(16'h03CA, 8'h00, "R11 feature");
    rd(16'h03CC, 8'h00, "R11 misc");
    rd(16'h03C4, 8'h00, "R11 seq index");
    rd(16'h03D4, 8'h00, "R11 crt index");
    rd(16'h03C0, 8'h00, "R11 att index");

    // R1 indexed groups
    wr(16'h03C4, 8'h02); wr(16'h03C5, 8'h0F);
    rd(16'h03C5, 8'h0F, "R1 seq data");
    rd(16'h03C4, 8'h02, "R1 seq index");
    wr(16'h03CE, 8'h05); wr(16'h03CF, 8'h40);
    rd(16'h03CF, 8'h40, "R1 gfx data");
    wr(16'h03D6, 8'h07); wr(16'h03D7, 8'h5A);
    rd(16'h03D7, 8'h5A, "R1 ext data");
    wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h8E);
    wr(16'h03B4, 8'h11);
    rd(16'h03B5, 8'h8E, "R1 mono alias data");
    wr(16'h03D4, 8'h31);
    rd(16'h03D5, 8'h8E, "R1 index low bits alias");
    rd(16'h03B4, 8'h31, "R1 full index readback");

    // R2 R3 attribute toggle
    rd(16'h03DA, 8'h00, "R4 status idle");
    wr(16'h03C0, 8'h10); wr(16'h03C0, 8'h41);
    wr(16'h03C0, 8'h12); wr(16'h03C0, 8'h99);
    wr(16'h03C0, 8'h10);
    rd(16'h03C0, 8'h10, "R2 third write is index");
    rd(16'h03C1, 8'h41, "R3 att data");
    wr(16'h03C1, 8'h77);
    rd(16'h03C1, 8'h41, "R3 write to 3C1 ignored");

    // R4 status clears toggle mid pair (toggle now at data state)
    vretrace_i = 1'b1;
    rd(16'h03DA, 8'h08, "R4 status retrace");
    wr(16'h03C0, 8'h12);
    rd(16'h03C0, 8'h12, "R4 toggle cleared by status");
    rd(16'h03C1, 8'h99, "R4 att data at new index");
    dispoff_i = 1'b1;
    rd(16'h03BA, 8'h09, "R4 status mono port");
    vretrace_i = 1'b0; dispoff_i = 1'b0;

    // R5 feature
    wr(16'h03DA, 8'h03);
    rd(16'h03CA, 8'h03, "R5 feature via 3DA");
    wr(16'h03BA, 8'h01);
    rd(16'h03CA, 8'h01, "R5 feature via 3BA");
    wr(16'h03CA, 8'hFF);
    rd(16'h03CA, 8'h01, "R5 write to 3CA ignored");

    // R6 misc
    wr(16'h03C2, 8'h67);
    rd(16'h03CC, 8'h67, "R6 misc readback");
    wr(16'h03CC, 8'h00);
    rd(16'h03CC, 8'h67, "R6 write to 3CC ignored");
    rd(16'h03C2, 8'h00, "R6 read 3C2 zero");

    // R7 mask
    wr(16'h03C6, 8'h3F);
    rd(16'h03C6, 8'h3F, "R7 mask write");

    // R8 R9 palette
    wr(16'h03C8, 8'h05);
    wr(16'h03C9, 8'h0A); wr(16'h03C9, 8'h0B); wr(16'h03C9, 8'h0C);
    wr(16'h03C9, 8'h1A); wr(16'h03C9, 8'h1B); wr(16'h03C9, 8'h1C);
    rd(16'h03C8, 8'h07, "R9 write index advanced");
    rd(16'h03C7, 8'h00, "R8 state write mode");
    wr(16'h03C7, 8'h05);
    rd(16'h03C7, 8'h03, "R8 state read mode");
    rd(16'h03C9, 8'h0A, "R9 read comp0");
    rd(16'h03C9, 8'h0B, "R9 read comp1");
    rd(16'h03C9, 8'h0C, "R9 read comp2");
    rd(16'h03C9, 8'h1A, "R9 read next entry");
    rd(16'h03C8, 8'h07, "R9 write index untouched by reads");
    wr(16'h03C7, 8'h06);
    rd(16'h03C9, 8'h1A, "R8 read count restarted");
    wr(16'h03C8, 8'h05); wr(16'h03C9, 8'h21);
    wr(16'h03C8, 8'h05);
    wr(16'h03C9, 8'h31); wr(16'h03C9, 8'h32); wr(16'h03C9, 8'h33);
    rd(16'h03C8, 8'h06, "R8 write count restarted");
    wr(16'h03C7, 8'h05);
    rd(16'h03C9, 8'h31, "R8 entry rewritten comp0");
    rd(16'h03C9, 8'h32, "R8 entry rewritten comp1");
    rd(16'h03C9, 8'h33, "R8 entry rewritten comp2");
    rd(16'h03C9, 8'h1A, "R9 neighbour entry intact");

    // R10 unmapped ports
    wr(16'h03C3, 8'hAA); wr(16'h03B0, 8'h55); wr(16'h03D8, 8'h12);
    wr(16'h03DF, 8'h34); wr(16'h03E0, 8'h56);
    rd(16'h03C3, 8'h00, "R10 read 3C3");
    rd(16'h03B0, 8'h00, "R10 read 3B0");
    rd(16'h03DF, 8'h00, "R10 read 3DF");
    rd(16'h03E0, 8'h00, "R10 read 3E0");
    rd(16'h03D5, 8'h8E, "R10 crt data intact");
    rd(16'h03C4, 8'h02, "R10 seq index intact");
    rd(16'h03CC, 8'h67, "R10 misc intact");
    rd(16'h03C6, 8'h3F, "R10 mask intact");

    // R12 hold after the last read
    rd(16'h03D7, 8'h5A, "R12 last read");
    repeat (4) @(negedge clk);
    chk(io_rdata, 8'h5A, "R12 rdata held");
    chk({7'b0, io_rvalid}, 8'h00, "R12 rvalid low when idle");
    chk(8'(exp_q.size()), 8'h00, "R12 pending reads");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule